// File: doc/BRIEF.md
# Character Display Refresh and Blink Sequencer

This block feeds a two-row, sixteen-column character display. It keeps 32 character codes in an internal memory and sends them out one position at a time in a fixed scan order. Each position comes out with its row, column and character code. Two qualifiers go with it: one blanks the character and one draws an underline mark beneath it. Font lookup and the drive of the physical display are left to logic downstream.

The appearance is set by a three-bit status word and a five-bit cursor position, both loaded through a write strobe. One status bit turns the whole display on or off. A second bit makes the whole display flash. A third bit makes an underline flash under the cursor position. The flash rate comes from a prescaler that is sized from the clock-frequency parameter. A new status word or cursor position takes effect only when the next frame begins, so a frame is never drawn with two different settings. The number of clocks spent on each position is set at an input.

Top module: `chardisp_refresh`

## Requirements
- R1: Positions are scanned row 0 columns 0 to 15, then row 1 columns 0 to 15, and the scan repeats. `charCode` carries the memory entry at index row*16+column of the position shown on `rowOut`/`colOut`.
- R2: Each position stays on the outputs for `holdCycles`+1 clocks. `frameStart` is high only during the first clock of position row 0, column 0.
- R3: A clock with `wrEn` high stores `wrData` at memory index `wrAddr`. The new code appears the next time that position is scanned.
- R4: A clock with `statWr` high captures `statData` and `cursorIn`. Bit 0 of `statData` is display enable, bit 1 is whole-display flash and bit 2 is cursor flash. The captured values take effect at the next frame start, and the frame in progress keeps its old settings.
- R5: While display enable is 0, `blankOut` is 1 at every position and `cursorMark` is 0, whatever the two flash bits are.
- R6: A flash phase toggles every CLK_HZ/(2*BLINK_HZ) clocks, which gives a 50 % duty cycle. The phase is sampled at each frame start. With display enable and whole-display flash both set, every position of a frame is blanked when the sampled phase is 1 and shown when it is 0.
- R7: With display enable and cursor flash both set, `cursorMark` is 1 at the cursor position in frames whose sampled phase is 0, and 0 in all other cases. Cursor flash never blanks the character.
- R8: During reset and after it, the display is disabled: `blankOut` is 1, `cursorMark` is 0 and `frameStart` is 0. The first frame starts on the first clock edge after reset is released.
- R9: With cursor flash 0, `cursorMark` stays 0 at every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| holdCycles | input | 8 | Clocks per position, minus one |
| wrEn | input | 1 | Character memory write strobe |
| wrAddr | input | 5 | Character memory index to write |
| wrData | input | 8 | Character code to store |
| statWr | input | 1 | Status and cursor write strobe |
| statData | input | 3 | Status word: bit0 enable, bit1 flash all, bit2 cursor flash |
| cursorIn | input | 5 | Cursor position captured with the status word |
| rowOut | output | 1 | Row of the position now shown |
| colOut | output | 4 | Column of the position now shown |
| charCode | output | 8 | Character code of the position now shown |
| blankOut | output | 1 | Position must be shown blank |
| cursorMark | output | 1 | Draw the underline mark at this position |
| frameStart | output | 1 | First clock of a frame |

## Verification
Two events can land in the same frame: a status write arriving while a frame is being scanned, and the frame boundary where that write becomes active. The bench writes a new status word and cursor while the eleventh position of a frame is on the outputs. It then checks that the rest of that frame still matches the old settings and that the next frame matches the new ones. One status word sets both flash bits, so the whole-display flash and the cursor mark act on the same positions in the same frames. There the bench expects the mark only in shown frames and never on a blanked position.

// File: rtl/chardisp_pkg.sv
`timescale 1ns/1ps
package chardisp_pkg;

  // Status word as applied to a frame.
  typedef struct packed {
    logic enable;
    logic blinkAll;
    logic blinkCursor;
  } dispStatus_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic advance;    // move to the next position this edge
    logic frameLoad;  // next position is the frame origin: apply pending settings
  } ctrlStrobe_t;

  // Field positions inside the written status word.
  localparam int STAT_EN_BIT  = 0;
  localparam int STAT_ALL_BIT = 1;
  localparam int STAT_CUR_BIT = 2;

  function automatic dispStatus_t decodeStatus(input logic [2:0] raw);
    dispStatus_t s;
    s.enable      = raw[STAT_EN_BIT];
    s.blinkAll    = raw[STAT_ALL_BIT];
    s.blinkCursor = raw[STAT_CUR_BIT];
    return s;
  endfunction

endpackage

// File: rtl/chardisp_ctrl.sv
`timescale 1ns/1ps
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int ROWS     = 2,
  parameter int COLS     = 16,
  parameter int HOLD_W   = 8,
  parameter int CLK_HZ   = 50_000_000,
  parameter int BLINK_HZ = 1,
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [HOLD_W-1:0] holdCycles,
  output ctrlStrobe_t       strobe,
  output logic [ROW_W-1:0]  rowIdx,
  output logic [COL_W-1:0]  colIdx,
  output logic              blinkPhase,
  output logic              frameStart
);

  localparam int HALF_RAW = CLK_HZ / (2 * BLINK_HZ);
  localparam int HALF     = (HALF_RAW > 0) ? HALF_RAW : 1;
  localparam int PRE_W    = $clog2(HALF + 1);

  logic              started;
  logic [HOLD_W-1:0] holdCnt;
  logic [PRE_W-1:0]  preCnt;
  logic              lastCol;
  logic              lastRow;

  assign lastCol = (colIdx == COL_W'(COLS - 1));
  assign lastRow = (rowIdx == ROW_W'(ROWS - 1));

  // The first edge after reset advances at once so the first frame opens immediately.
  always_comb begin
    strobe.advance   = !started || (holdCnt >= holdCycles);
    strobe.frameLoad = strobe.advance && lastCol && lastRow;
  end

  // Position sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      started    <= 1'b0;
      holdCnt    <= '0;
      rowIdx     <= ROW_W'(ROWS - 1);
      colIdx     <= COL_W'(COLS - 1);
      frameStart <= 1'b0;
    end else begin
      started    <= 1'b1;
      frameStart <= strobe.frameLoad;
      if (strobe.advance) begin
        holdCnt <= '0;
        if (lastCol) begin
          colIdx <= '0;
          rowIdx <= lastRow ? '0 : rowIdx + 1'b1;
        end else begin
          colIdx <= colIdx + 1'b1;
        end
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  // Flash prescaler: the phase toggles every HALF clocks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt     <= '0;
      blinkPhase <= 1'b0;
    end else if (preCnt == PRE_W'(HALF - 1)) begin
      preCnt     <= '0;
      blinkPhase <= !blinkPhase;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/chardisp_datapath.sv
`timescale 1ns/1ps
module chardisp_datapath
  import chardisp_pkg::*;
#(
  parameter int ROWS    = 2,
  parameter int COLS    = 16,
  parameter int CHAR_W  = 8,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int POSITIONS = ROWS * COLS,
  localparam int POS_W  = (POSITIONS > 1) ? $clog2(POSITIONS) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic [COL_W-1:0]  colIdx,
  input  logic              blinkPhase,
  input  logic              wrEn,
  input  logic [POS_W-1:0]  wrAddr,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              statWr,
  input  logic [2:0]        statData,
  input  logic [POS_W-1:0]  cursorIn,
  output logic [CHAR_W-1:0] charCode,
  output logic              blankOut,
  output logic              cursorMark
);

  logic [CHAR_W-1:0] cells [POSITIONS];
  dispStatus_t       pendStat;
  dispStatus_t       actStat;
  logic [POS_W-1:0]  pendCursor;
  logic [POS_W-1:0]  actCursor;
  logic              actPhase;
  logic [POS_W-1:0]  posIdx;

  assign posIdx = POS_W'(rowIdx) * POS_W'(COLS) + POS_W'(colIdx);

  // Character memory
  always_ff @(posedge clk) begin
    if (wrEn) cells[wrAddr] <= wrData;
  end

  // Pending settings, written at any time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendStat   <= '0;
      pendCursor <= '0;
    end else if (statWr) begin
      pendStat   <= decodeStatus(statData);
      pendCursor <= cursorIn;
    end
  end

  // Active settings, swapped in only at the frame boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actStat   <= '0;
      actCursor <= '0;
      actPhase  <= 1'b0;
    end else if (strobe.frameLoad) begin
      actStat   <= pendStat;
      actCursor <= pendCursor;
      actPhase  <= blinkPhase;
    end
  end

  always_comb begin
    charCode   = cells[posIdx];
    blankOut   = !actStat.enable || (actStat.blinkAll && actPhase);
    cursorMark = actStat.enable && actStat.blinkCursor && !actPhase
                 && (posIdx == actCursor);
  end

endmodule

// File: rtl/chardisp_refresh.sv
`timescale 1ns/1ps
module chardisp_refresh
  import chardisp_pkg::*;
#(
  parameter int ROWS     = 2,
  parameter int COLS     = 16,
  parameter int CHAR_W   = 8,
  parameter int HOLD_W   = 8,
  parameter int CLK_HZ   = 50_000_000,
  parameter int BLINK_HZ = 1,
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int POS_W   = (ROWS * COLS > 1) ? $clog2(ROWS * COLS) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic              wrEn,
  input  logic [POS_W-1:0]  wrAddr,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              statWr,
  input  logic [2:0]        statData,
  input  logic [POS_W-1:0]  cursorIn,
  output logic [ROW_W-1:0]  rowOut,
  output logic [COL_W-1:0]  colOut,
  output logic [CHAR_W-1:0] charCode,
  output logic              blankOut,
  output logic              cursorMark,
  output logic              frameStart
);

  ctrlStrobe_t strobe;
  logic        blinkPhase;

  chardisp_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .HOLD_W(HOLD_W),
    .CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .holdCycles(holdCycles),
    .strobe(strobe), .rowIdx(rowOut), .colIdx(colOut),
    .blinkPhase(blinkPhase), .frameStart(frameStart)
  );

  chardisp_datapath #(
    .ROWS(ROWS), .COLS(COLS), .CHAR_W(CHAR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rowIdx(rowOut), .colIdx(colOut), .blinkPhase(blinkPhase),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statWr(statWr), .statData(statData), .cursorIn(cursorIn),
    .charCode(charCode), .blankOut(blankOut), .cursorMark(cursorMark)
  );

endmodule

// File: rtl/chardisp_refresh_chk.sv
`timescale 1ns/1ps
module chardisp_refresh_chk #(
  parameter int ROW_W = 1,
  parameter int COL_W = 4
)(
  input logic             clk,
  input logic             rstN,
  input logic [ROW_W-1:0] rowOut,
  input logic [COL_W-1:0] colOut,
  input logic             blankOut,
  input logic             cursorMark,
  input logic             frameStart
);

  assert_frame_origin_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (rowOut == '0) && (colOut == '0));

  assert_single_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  assert_scan_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && (colOut != $past(colOut))) |->
      ((colOut == $past(colOut) + 1'b1) && (rowOut == $past(rowOut))) ||
      ((colOut == '0) && (rowOut == $past(rowOut) + 1'b1)));

  assert_blank_frame_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |-> $stable(blankOut));

  assert_mark_not_blanked_R7: assert property (@(posedge clk) disable iff (!rstN)
    cursorMark |-> !blankOut);

endmodule

bind chardisp_refresh chardisp_refresh_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .rowOut(rowOut), .colOut(colOut),
  .blankOut(blankOut), .cursorMark(cursorMark), .frameStart(frameStart)
);

// File: tb/chardisp_refresh_tb.sv
`timescale 1ns/1ps
module chardisp_refresh_tb;

  localparam int POS      = 32;
  localparam int CLK_HZ   = 256;   // flash half period 128 clocks = 4 frames at hold 0
  localparam int BLINK_HZ = 1;

  // Vector: {status[2:0], cursor[4:0]}; status bit0 enable, bit1 flash all, bit2 cursor flash
  localparam logic [7:0] VEC [8] = '{
    {3'b001, 5'd3},  {3'b101, 5'd17}, {3'b011, 5'd0},  {3'b111, 5'd31},
    {3'b110, 5'd5},  {3'b000, 5'd9},  {3'b101, 5'd15}, {3'b001, 5'd16}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] holdCycles;
  logic       wrEn;
  logic [4:0] wrAddr;
  logic [7:0] wrData;
  logic       statWr;
  logic [2:0] statData;
  logic [4:0] cursorIn;
  logic       rowOut;
  logic [3:0] colOut;
  logic [7:0] charCode;
  logic       blankOut;
  logic       cursorMark;
  logic       frameStart;

  logic [7:0] memModel [POS];
  int checks = 0;
  int errors = 0;
  int frameCnt;

  chardisp_refresh #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ)) u_dut (
    .clk(clk), .rstN(rstN), .holdCycles(holdCycles),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statWr(statWr), .statData(statData), .cursorIn(cursorIn),
    .rowOut(rowOut), .colOut(colOut), .charCode(charCode),
    .blankOut(blankOut), .cursorMark(cursorMark), .frameStart(frameStart)
  );

  always #2.5 clk = ~clk;

  // Frames seen since reset; read before update at each negedge
  always @(negedge clk) begin
    if (!rstN) frameCnt <= 0;
    else if (frameStart) frameCnt <= frameCnt + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitFrame();
    do @(negedge clk); while (frameStart !== 1'b1);
  endtask

  // Called at the negedge where frameStart is high; checks all 32 positions
  task automatic checkFrame(input logic [2:0] st, input logic [4:0] cur,
                            input bit doWr, input logic [2:0] nst, input logic [4:0] ncur);
    bit ph = ((frameCnt / 4) % 2) == 1;
    for (int p = 0; p < POS; p++) begin
      bit expBlank;
      bit expMark;
      if (p > 0) @(negedge clk);
      expBlank = !st[0] || (st[1] && ph);
      expMark  = st[0] && st[2] && !ph && (p == int'(cur));
      chk("R1", "row", int'(rowOut), p / 16);
      chk("R1", "col", int'(colOut), p % 16);
      chk("R1", "char", int'(charCode), int'(memModel[p]));
      chk(st[0] ? "R6" : "R5", "blank", int'(blankOut), int'(expBlank));
      chk(st[2] ? "R7" : "R9", "cursor", int'(cursorMark), int'(expMark));
      chk("R2", "frameStart", int'(frameStart), int'(p == 0));
      if (doWr && p == 10) begin
        statWr = 1'b1; statData = nst; cursorIn = ncur;   // R4: mid-frame write
      end
      if (p == 11) statWr = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; holdCycles = 8'd0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    statWr = 1'b0; statData = '0; cursorIn = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "blank in reset", int'(blankOut), 1);
    chk("R8", "cursor in reset", int'(cursorMark), 0);
    chk("R8", "frameStart in reset", int'(frameStart), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8", "first frame start", int'(frameStart), 1);
    chk("R8", "first row", int'(rowOut), 0);
    chk("R8", "first col", int'(colOut), 0);
    chk("R8", "blank after reset", int'(blankOut), 1);

    // R3: fill memory
    for (int a = 0; a < POS; a++) begin
      wrEn = 1'b1; wrAddr = 5'(a); wrData = 8'(8'h30 + a * 3);
      memModel[a] = 8'(8'h30 + a * 3);
      @(negedge clk);
    end
    wrEn = 1'b0;

    // Disabled frame, writing the first vector in mid-frame (R4, R5)
    waitFrame();
    checkFrame(3'b000, 5'd0, 1'b1, VEC[0][7:5], VEC[0][4:0]);

    // Vector walk: 8 frames each, covering both flash phases
    for (int i = 0; i < 8; i++) begin
      for (int f = 0; f < 8; f++) begin
        waitFrame();
        if (f == 7 && i < 7)
          checkFrame(VEC[i][7:5], VEC[i][4:0], 1'b1, VEC[i+1][7:5], VEC[i+1][4:0]);
        else
          checkFrame(VEC[i][7:5], VEC[i][4:0], 1'b0, 3'b000, 5'd0);
      end
    end

    // R3: rewrite one position during a frame
    waitFrame();
    wrEn = 1'b1; wrAddr = 5'd20; wrData = 8'hA5; memModel[20] = 8'hA5;
    @(negedge clk);
    wrEn = 1'b0;
    waitFrame();
    checkFrame(VEC[7][7:5], VEC[7][4:0], 1'b0, 3'b000, 5'd0);

    // R2: hold of three clocks per position
    rstN = 1'b0; holdCycles = 8'd2;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    waitFrame();
    for (int k = 0; k < 3 * POS; k++) begin
      if (k > 0) @(negedge clk);
      chk("R2", "held index", int'(rowOut) * 16 + int'(colOut), k / 3);
      chk("R2", "frameStart in hold frame", int'(frameStart), int'(k == 0));
    end
    @(negedge clk);
    chk("R2", "frame period 96", int'(frameStart), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule